// File: doc/BRIEF.md
# Byte-Window Pointer Register File

This block sits on an 8-bit processor bus. It holds three 16-bit pointers: a display-list pointer and two data-port addresses. Software does not see a separate low and high byte location for each pointer. Each pointer is reached through one 8-bit window index instead. A one-bit byte selector in each window picks the low or the high half, and it flips on every access to that window. Writes fill a 16-bit staging register, and reads return bytes of that staging register.

A staged value reaches its active output only when a commit event occurs:
- For the display-list pointer, the commit event is an access to the display-list strobe index or a frame-start pulse.
- For each data-port address, the commit event is an access to the matching port index.

Accessing the strobe index or a port index also returns the matching window's byte selector to the low byte. Writing the clear bit of the control index returns all three selectors to the low byte. This lets software restart a sequence it has lost track of.

Top module: `ptr_window_regs`

## Requirements
- R1: During reset, all byte selectors, staging registers, active pointers and `rdata` are zero, and every selector points at the low byte.
- R2: Index map: 0 is the display-list window, 1 is the display-list strobe, 2 is the address-0 window, 3 is the address-1 window, 4 is port 0, 5 is port 1 and 6 is control. A write to a window stores the byte in the low half of its staging register when the selector is low, and in the high half when it is high.
- R3: The byte selector of a window flips on every access to that window, whether read or write. A read returns the staged byte that the selector picks. The byte appears on `rdata` one cycle after the read strobe.
- R4: Any access (read or write) to index 1 copies the display-list staging value to `dl_ptr` in one cycle. The same access sets that window's selector to the low byte.
- R5: A one-cycle `frame_start` pulse copies the display-list staging value to `dl_ptr`. It leaves the byte selector unchanged.
- R6: Any access to index 4 (or 5) copies the address-0 (or address-1) staging value to `port0_addr` (or `port1_addr`). The same access sets only that window's selector to the low byte.
- R7: A write to index 6 with data bit 6 set sets all three selectors to the low byte. It commits nothing. With bit 6 clear the write has no effect.
- R8: An active pointer output changes only on its own commit event. A window write alone leaves it unchanged.
- R9: Strobes given while `cs` is low are ignored.
- R10: A read of an index that is not a window returns 0. `rdata` holds its value while no read occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| idx | input | 4 | Register index |
| rd | input | 1 | Read strobe |
| wr | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| frame_start | input | 1 | Frame-start pulse, commits the display-list pointer |
| rdata | output | 8 | Registered read data |
| dl_ptr | output | 16 | Active display-list pointer |
| port0_addr | output | 16 | Active address for port 0 |
| port1_addr | output | 16 | Active address for port 1 |

## Verification
The assertions check the following on every cycle:
- each active pointer holds outside its commit events;
- a commit copies exactly the staging value of the previous cycle;
- a window access flips its selector, and a control clear zeroes every selector;
- deselected strobes and idle cycles leave state and `rdata` alone.

Some behaviours appear only in the bench's scenarios. These are the byte ordering that a sequence of writes and reads produces, the restart after a strobe or port access partway through a pair, and the fact that a frame-start commit leaves a half-written pair intact. The bench's reference model exercises these across mixed read and write sequences.

// File: rtl/ptr_window_pkg.sv
package ptr_window_pkg;
  localparam int NUM_WIN = 3;
  localparam int WIN_DL  = 0;
  localparam int WIN_A0  = 1;
  localparam int WIN_A1  = 2;

  typedef enum logic [3:0] {
    IDX_DLWIN = 4'd0,
    IDX_DLSTB = 4'd1,
    IDX_A0WIN = 4'd2,
    IDX_A1WIN = 4'd3,
    IDX_PORT0 = 4'd4,
    IDX_PORT1 = 4'd5,
    IDX_CTRL  = 4'd6
  } reg_idx_e;
endpackage

// File: rtl/ptr_bus_decode.sv
module ptr_bus_decode
  import ptr_window_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CTRL_CLR_BIT = 6
) (
  input  logic              cs,
  input  logic              rd,
  input  logic              wr,
  input  logic [3:0]        idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic              frame_start,
  output logic [NUM_WIN-1:0] win_acc,
  output logic [NUM_WIN-1:0] win_wr,
  output logic [NUM_WIN-1:0] win_clr,
  output logic [NUM_WIN-1:0] win_commit
);
  logic bus_acc;

  always_comb begin
    bus_acc    = cs & (rd | wr);
    win_acc    = '0;
    win_wr     = '0;
    win_clr    = '0;
    win_commit = '0;
    case (idx)
      IDX_DLWIN: begin
        win_acc[WIN_DL] = bus_acc;
        win_wr[WIN_DL]  = cs & wr;
      end
      IDX_A0WIN: begin
        win_acc[WIN_A0] = bus_acc;
        win_wr[WIN_A0]  = cs & wr;
      end
      IDX_A1WIN: begin
        win_acc[WIN_A1] = bus_acc;
        win_wr[WIN_A1]  = cs & wr;
      end
      IDX_DLSTB: begin
        win_clr[WIN_DL]    = bus_acc;
        win_commit[WIN_DL] = bus_acc;
      end
      IDX_PORT0: begin
        win_clr[WIN_A0]    = bus_acc;
        win_commit[WIN_A0] = bus_acc;
      end
      IDX_PORT1: begin
        win_clr[WIN_A1]    = bus_acc;
        win_commit[WIN_A1] = bus_acc;
      end
      IDX_CTRL: begin
        if (cs && wr && wdata[CTRL_CLR_BIT]) win_clr = '1;
      end
      default: ;
    endcase
    win_commit[WIN_DL] = win_commit[WIN_DL] | frame_start;
  end
endmodule

// File: rtl/ptr_byte_window.sv
module ptr_byte_window #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc,
  input  logic                wr_en,
  input  logic                clr,
  input  logic                commit,
  input  logic [DATA_W-1:0]   wdata,
  output logic                hi_sel,
  output logic [2*DATA_W-1:0] staged,
  output logic [2*DATA_W-1:0] active
);
  localparam int PTR_W = 2 * DATA_W;

  logic             hi_q, hi_d, hi_en;
  logic [PTR_W-1:0] stg_q, stg_d;
  logic [PTR_W-1:0] act_q, act_d;
  logic             stg_en, act_en;

  // next state: a clear outranks the toggle and steers a same-cycle write low
  always_comb begin
    hi_en  = clr | acc;
    hi_d   = clr ? 1'b0 : ~hi_q;
    stg_en = wr_en;
    stg_d  = stg_q;
    if (hi_q && !clr) stg_d[PTR_W-1:DATA_W] = wdata;
    else              stg_d[DATA_W-1:0]     = wdata;
    act_en = commit;
    act_d  = stg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q  <= 1'b0;
      stg_q <= '0;
      act_q <= '0;
    end else begin
      if (hi_en)  hi_q  <= hi_d;
      if (stg_en) stg_q <= stg_d;
      if (act_en) act_q <= act_d;
    end
  end

  assign hi_sel = hi_q;
  assign staged = stg_q;
  assign active = act_q;
endmodule

// File: rtl/ptr_window_regs.sv
module ptr_window_regs
  import ptr_window_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int CTRL_CLR_BIT = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs,
  input  logic [3:0]          idx,
  input  logic                rd,
  input  logic                wr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                frame_start,
  output logic [DATA_W-1:0]   rdata,
  output logic [2*DATA_W-1:0] dl_ptr,
  output logic [2*DATA_W-1:0] port0_addr,
  output logic [2*DATA_W-1:0] port1_addr
);
  localparam int PTR_W = 2 * DATA_W;

  logic [NUM_WIN-1:0]       win_acc, win_wr, win_clr, win_commit;
  logic [NUM_WIN-1:0]       hi_flat;
  logic [NUM_WIN*PTR_W-1:0] stg_flat;
  logic [NUM_WIN*PTR_W-1:0] act_flat;
  logic [DATA_W-1:0]        rd_mux;
  logic [DATA_W-1:0]        rdata_q;
  logic                     rdata_en;

  ptr_bus_decode #(.DATA_W(DATA_W), .CTRL_CLR_BIT(CTRL_CLR_BIT)) u_dec (
    .cs(cs), .rd(rd), .wr(wr), .idx(idx), .wdata(wdata),
    .frame_start(frame_start),
    .win_acc(win_acc), .win_wr(win_wr), .win_clr(win_clr), .win_commit(win_commit)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    ptr_byte_window #(.DATA_W(DATA_W)) u_win (
      .clk(clk), .rst_n(rst_n),
      .acc(win_acc[w]), .wr_en(win_wr[w]), .clr(win_clr[w]), .commit(win_commit[w]),
      .wdata(wdata),
      .hi_sel(hi_flat[w]),
      .staged(stg_flat[w*PTR_W +: PTR_W]),
      .active(act_flat[w*PTR_W +: PTR_W])
    );
  end

  function automatic logic [DATA_W-1:0] pick_byte(input logic [PTR_W-1:0] v, input logic hi);
    return hi ? v[PTR_W-1:DATA_W] : v[DATA_W-1:0];
  endfunction

  always_comb begin
    rdata_en = cs & rd;
    case (idx)
      IDX_DLWIN: rd_mux = pick_byte(stg_flat[WIN_DL*PTR_W +: PTR_W], hi_flat[WIN_DL]);
      IDX_A0WIN: rd_mux = pick_byte(stg_flat[WIN_A0*PTR_W +: PTR_W], hi_flat[WIN_A0]);
      IDX_A1WIN: rd_mux = pick_byte(stg_flat[WIN_A1*PTR_W +: PTR_W], hi_flat[WIN_A1]);
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rdata_q <= '0;
    else if (rdata_en) rdata_q <= rd_mux;
  end

  assign rdata      = rdata_q;
  assign dl_ptr     = act_flat[WIN_DL*PTR_W +: PTR_W];
  assign port0_addr = act_flat[WIN_A0*PTR_W +: PTR_W];
  assign port1_addr = act_flat[WIN_A1*PTR_W +: PTR_W];
endmodule

// File: rtl/ptr_window_chk.sv
module ptr_window_chk #(
  parameter int DATA_W       = 8,
  parameter int CTRL_CLR_BIT = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cs,
  input logic [3:0]          idx,
  input logic                rd,
  input logic                wr,
  input logic [DATA_W-1:0]   wdata,
  input logic                frame_start,
  input logic [DATA_W-1:0]   rdata,
  input logic [2*DATA_W-1:0] dl_ptr,
  input logic [2*DATA_W-1:0] port0_addr,
  input logic [2*DATA_W-1:0] port1_addr,
  input logic [2:0]          hi_flat,
  input logic [6*DATA_W-1:0] stg_flat
);
  localparam int PW = 2 * DATA_W;
  logic acc;
  assign acc = cs & (rd | wr);

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_state_R1: assert (hi_flat == '0 && stg_flat == '0 && rdata == '0
                                      && dl_ptr == '0 && port0_addr == '0 && port1_addr == '0);
    end
  end

  assert_dl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(acc && idx == 4'd1) && !frame_start) |=> $stable(dl_ptr));

  assert_dl_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx == 4'd1) |=> (dl_ptr == $past(stg_flat[PW-1:0]) && !hi_flat[0]));

  assert_frame_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !acc) |=> (dl_ptr == $past(stg_flat[PW-1:0]) && hi_flat[0] == $past(hi_flat[0])));

  assert_p0_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx == 4'd4) |=> (port0_addr == $past(stg_flat[2*PW-1:PW]) && !hi_flat[1]
                              && $stable(port1_addr)));

  assert_p1_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc && idx == 4'd5) |=> $stable(port1_addr));

  assert_ctrl_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr && idx == 4'd6 && wdata[CTRL_CLR_BIT]) |=> (hi_flat == 3'b000));

  assert_win_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && idx == 4'd0) |=> (hi_flat[0] != $past(hi_flat[0])));

  assert_deselect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> ($stable(stg_flat) && $stable(hi_flat) && $stable(port0_addr) && $stable(port1_addr)));

  assert_rdata_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && rd) |=> $stable(rdata));
endmodule

bind ptr_window_regs ptr_window_chk #(.DATA_W(DATA_W), .CTRL_CLR_BIT(CTRL_CLR_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .idx(idx), .rd(rd), .wr(wr), .wdata(wdata),
  .frame_start(frame_start), .rdata(rdata), .dl_ptr(dl_ptr), .port0_addr(port0_addr),
  .port1_addr(port1_addr), .hi_flat(hi_flat), .stg_flat(stg_flat)
);

// File: tb/ptr_window_regs_bench.sv
module ptr_window_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs = 1'b0, rd = 1'b0, wr = 1'b0, frame_start = 1'b0;
  logic [3:0]  idx = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [15:0] dl_ptr, port0_addr, port1_addr;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  // reference model state
  int m_stg[3];
  int m_act[3];
  int m_hi[3];
  int m_rdata;

  always #10 clk = ~clk;

  ptr_window_regs u_ptr_window_regs (
    .clk(clk), .rst_n(rst_n), .cs(cs), .idx(idx), .rd(rd), .wr(wr), .wdata(wdata),
    .frame_start(frame_start), .rdata(rdata), .dl_ptr(dl_ptr),
    .port0_addr(port0_addr), .port1_addr(port1_addr)
  );

  function automatic int win_of(input int i);
    case (i)
      0: return 0;
      2: return 1;
      3: return 2;
      default: return -1;
    endcase
  endfunction

  initial begin
    foreach (m_stg[k]) begin m_stg[k] = 0; m_act[k] = 0; m_hi[k] = 0; end
    m_rdata = 0;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_stg[k]) begin m_stg[k] = 0; m_act[k] = 0; m_hi[k] = 0; end
      m_rdata = 0;
    end else begin
      int w;
      bit a;
      a = cs && (rd || wr);
      w = win_of(int'(idx));
      if (cs && rd) m_rdata = (w >= 0) ? ((m_hi[w] != 0) ? (m_stg[w] >> 8) & 255 : m_stg[w] & 255) : 0;
      if ((a && idx == 4'd1) || frame_start) m_act[0] = m_stg[0];
      if (a && idx == 4'd4) m_act[1] = m_stg[1];
      if (a && idx == 4'd5) m_act[2] = m_stg[2];
      if (a && idx == 4'd1) m_hi[0] = 0;
      if (a && idx == 4'd4) m_hi[1] = 0;
      if (a && idx == 4'd5) m_hi[2] = 0;
      if (cs && wr && idx == 4'd6 && wdata[6]) foreach (m_hi[k]) m_hi[k] = 0;
      if (a && w >= 0) begin
        if (wr) begin
          if (m_hi[w] != 0) m_stg[w] = (m_stg[w] & 255) | (int'(wdata) << 8);
          else              m_stg[w] = (m_stg[w] & 65280) | int'(wdata);
        end
        m_hi[w] = 1 - m_hi[w];
      end
    end
  end

  task automatic check(input string tag, input int actual, input int expected);
    tests++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // compare with the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 model rdata", int'(rdata), m_rdata);
      check("R4 model dl_ptr", int'(dl_ptr), m_act[0]);
      check("R6 model port0_addr", int'(port0_addr), m_act[1]);
      check("R6 model port1_addr", int'(port1_addr), m_act[2]);
    end
  end

  task automatic bus(input bit sel, input bit r, input bit w, input logic [3:0] i, input logic [7:0] d);
    @(negedge clk);
    cs = sel; rd = r; wr = w; idx = i; wdata = d;
    @(negedge clk);
    cs = 0; rd = 0; wr = 0; idx = '0; wdata = '0;
  endtask

  task automatic wr_reg(input logic [3:0] i, input logic [7:0] d);
    bus(1, 0, 1, i, d);
  endtask

  task automatic rd_reg(input logic [3:0] i, output logic [7:0] d);
    bus(1, 1, 0, i, 8'h00);
    d = rdata;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    frame_start = 1;
    @(negedge clk);
    frame_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    check("R1 reset rdata", int'(rdata), 0);
    check("R1 reset dl_ptr", int'(dl_ptr), 0);
    check("R1 reset port0", int'(port0_addr), 0);
    @(negedge clk);
    rst_n = 1;

    // R2 R8: two writes fill low then high, active untouched
    wr_reg(4'd0, 8'h34);
    wr_reg(4'd0, 8'h12);
    check("R8 dl_ptr before strobe", int'(dl_ptr), 0);
    rd_reg(4'd0, d); check("R2 R3 first read low", int'(d), 'h34);
    rd_reg(4'd0, d); check("R2 R3 second read high", int'(d), 'h12);
    wr_reg(4'd1, 8'h00);
    check("R4 strobe write commit", int'(dl_ptr), 'h1234);

    // R4: strobe read resets selector mid-pair
    rd_reg(4'd0, d); check("R3 read low", int'(d), 'h34);
    rd_reg(4'd1, d); check("R10 strobe read value", int'(d), 0);
    rd_reg(4'd0, d); check("R4 selector reset by strobe read", int'(d), 'h34);

    // R6: port access commits and restarts sequence
    rd_reg(4'd1, d);
    wr_reg(4'd2, 8'hCD);
    rd_reg(4'd4, d);
    check("R6 port0 commit", int'(port0_addr), 'h00CD);
    wr_reg(4'd2, 8'hEF);
    wr_reg(4'd2, 8'hAB);
    wr_reg(4'd4, 8'h00);
    check("R6 port0 after restart", int'(port0_addr), 'hABEF);
    check("R6 port1 untouched", int'(port1_addr), 0);

    // R5: frame commit leaves a half-written pair intact
    wr_reg(4'd0, 8'h78);
    wr_reg(4'd0, 8'h56);
    wr_reg(4'd0, 8'h9A);
    frame_pulse();
    check("R5 frame commit", int'(dl_ptr), 'h569A);
    wr_reg(4'd0, 8'hBC);
    wr_reg(4'd1, 8'h00);
    check("R5 selector kept across frame", int'(dl_ptr), 'hBC9A);

    // R7: control clear bit
    wr_reg(4'd3, 8'h11);
    wr_reg(4'd6, 8'h00);
    wr_reg(4'd3, 8'h33);
    wr_reg(4'd5, 8'h00);
    check("R7 clear bit low has no effect", int'(port1_addr), 'h3311);
    wr_reg(4'd3, 8'h44);
    wr_reg(4'd6, 8'h40);
    check("R7 no commit on control", int'(port1_addr), 'h3311);
    wr_reg(4'd3, 8'h55);
    wr_reg(4'd5, 8'h00);
    check("R7 clear restarts at low byte", int'(port1_addr), 'h3355);

    // R9: deselected strobes ignored
    bus(0, 0, 1, 4'd2, 8'hFF);
    bus(0, 1, 0, 4'd4, 8'h00);
    check("R9 port0 unchanged", int'(port0_addr), 'hABEF);
    rd_reg(4'd2, d); check("R9 staged low unchanged", int'(d), 'hEF);
    bus(0, 1, 0, 4'd2, 8'h00);
    check("R9 rdata unchanged", int'(rdata), 'hEF);

    // R10: non-window read and hold
    rd_reg(4'd6, d); check("R10 control reads zero", int'(d), 0);
    rd_reg(4'd2, d); check("R3 high after toggle", int'(d), 'hAB);
    repeat (3) @(negedge clk);
    check("R10 rdata holds", int'(rdata), 'hAB);

    repeat (2) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule